// File: doc/BRIEF.md
# Ladder Power-Mode Time-Slice Sequencer

This block sets the drive strength of the on-chip bias reference ladder of a segment display controller. Each repeating display interval is divided into two windows. An "A" window comes first and a "B" window follows. During each window the block drives a 2-bit power level taken from one of two programmable settings. Software writes one 8-bit control register. That register holds the power level for each window and the length of the A window, counted in display ticks.

A tick-enable from the display time base advances the position inside the interval. An interval-start strobe realigns the position with the waveform generator. A waveform-type input selects either a 16-tick or a 32-tick interval. Both the window lengths and the interval length are latched only at an interval boundary. Because of this, a window is never cut short by a register write or a change of waveform type.

Top module: `ladder_pwr_seq`

## Requirements
- R1: After reset the register reads 0x00, `pwr_lvl` is 00 and `a_phase` is 0.
- R2: The register holds the A-window level in bits 7:6, the B-window level in bits 5:4 and the A-window length N in bits 2:0. A write is visible on `reg_rdata` after the clock edge that takes it. Bit 3 always reads 0, even when it is written as 1.
- R3: `pwr_lvl` carries the selected 2-bit level unchanged. The codes are 11 for high power, 10 for medium power, 01 for low power and 00 for off and disconnected.
- R4: With the latched waveform type at 0, an interval is 16 ticks long. The position advances 0 through 15 and wraps to 0. Positions 0 to N−1 drive the A level, and positions N to 15 drive the B level.
- R5: With the latched waveform type at 1, an interval is 32 ticks long. The position advances 0 through 31 and wraps to 0. Positions 0 to N−1 drive the A level, and positions N to 31 drive the B level.
- R6: With N = 0, the B level is driven for the whole interval and `a_phase` stays 0.
- R7: The position advances only on a cycle with `tick_en` high. On other cycles `pwr_lvl` and `a_phase` hold.
- R8: An `ivl_start` pulse sets the position to 0, and this takes priority over a tick in the same cycle.
- R9: The register contents and the waveform type are taken into use only at an interval boundary. A boundary is an `ivl_start` pulse or the wrap from the last position. A write in the middle of an interval does not change the current interval.
- R10: `a_phase` is 1 exactly while the A level is driven, and 0 during the B window.
- R11: `pwr_lvl` and `a_phase` are registered. They change on the same clock edge that moves the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| wave_long | input | 1 | Waveform type: 0 gives 16-tick intervals, 1 gives 32-tick intervals |
| tick_en | input | 1 | Display time-base tick |
| ivl_start | input | 1 | Interval-start strobe |
| pwr_lvl | output | 2 | Ladder power level |
| a_phase | output | 1 | High during the A window |

## Verification
A wrong position count shows on the next tick as an early or late A-to-B edge, or as a wrap at the wrong length. The bench catches it because it checks every tick position across two full intervals for each setting. A configuration latched at the wrong moment shows at the first boundary after a mid-interval write or waveform change. The bench checks the last positions before that boundary and the first ones after it. A level routed to the wrong window appears at once as a mismatch of `pwr_lvl` against `a_phase`.

// File: rtl/ladder_pwr_seq.sv
module ladder_pwr_seq #(
  parameter int SHORT_TICKS = 16,
  parameter int LONG_TICKS  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       wave_long,
  input  logic       tick_en,
  input  logic       ivl_start,
  output logic [1:0] pwr_lvl,
  output logic       a_phase
);
  localparam int CW = $clog2(LONG_TICKS);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

  logic [6:0]    cfg_q;
  logic [1:0]    act_a_q, act_b_q;
  logic [2:0]    act_n_q;
  logic          act_long_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    pwr_q;
  logic          aph_q;

  logic [CW-1:0] last_pos, cnt_d;
  logic [1:0]    a_d, b_d;
  logic [2:0]    n_d;
  logic          wrap, load, in_a_d;

  assign reg_rdata = {cfg_q[6:3], 1'b0, cfg_q[2:0]};
  assign pwr_lvl   = pwr_q;
  assign a_phase   = aph_q;

  assign last_pos = act_long_q ? LONG_LAST : SHORT_LAST;
  assign wrap     = tick_en && (cnt_q == last_pos);
  assign load     = ivl_start || wrap;

  assign cnt_d  = load ? '0 : (tick_en ? cnt_q + 1'b1 : cnt_q);
  assign a_d    = load ? cfg_q[6:5] : act_a_q;
  assign b_d    = load ? cfg_q[4:3] : act_b_q;
  assign n_d    = load ? cfg_q[2:0] : act_n_q;
  assign in_a_d = cnt_d < CW'(n_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (reg_wr_en) begin
      cfg_q <= {reg_wdata[7:4], reg_wdata[2:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a_q    <= '0;
      act_b_q    <= '0;
      act_n_q    <= '0;
      act_long_q <= 1'b0;
      cnt_q      <= '0;
      pwr_q      <= '0;
      aph_q      <= 1'b0;
    end else begin
      act_a_q <= a_d;
      act_b_q <= b_d;
      act_n_q <= n_d;
      if (load) act_long_q <= wave_long;
      cnt_q <= cnt_d;
      pwr_q <= in_a_d ? a_d : b_d;
      aph_q <= in_a_d;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_pos);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ivl_start) |=> ($stable(cnt_q) && $stable(pwr_lvl) && $stable(a_phase)));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_start |=> (cnt_q == '0));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_n_q) && $stable(act_a_q) && $stable(act_b_q) && $stable(act_long_q)));

  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_n_q == 3'd0) |-> !a_phase);

  // R10
  phase_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_lvl == (a_phase ? act_a_q : act_b_q));

  // R2
  always_comb rsvd_zero_chk: assert (!rst_n || reg_rdata[3] == 1'b0);
endmodule

// File: tb/ladder_pwr_seq_bench.sv
`timescale 1ns/1ps
module ladder_pwr_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic wave_long = 1'b0;
  logic tick_en = 1'b0;
  logic ivl_start = 1'b0;
  logic [1:0] pwr_lvl;
  logic a_phase;

  always #2.5 clk = ~clk;

  ladder_pwr_seq u_ladder_pwr_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wave_long(wave_long), .tick_en(tick_en),
    .ivl_start(ivl_start), .pwr_lvl(pwr_lvl), .a_phase(a_phase));

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [7:0] m_cfg = '0;
  int m_pos = 0, m_len = 16, m_n = 0;
  logic [1:0] m_a = '0, m_b = '0;

  // {wave, cfg}
  localparam logic [8:0] VEC [6] = '{
    9'h0_E3, 9'h1_97, 9'h0_5F, 9'h1_D0, 9'h0_C1, 9'h1_34 };

  task automatic check(string req);
    logic [1:0] ep;
    logic eph;
    logic [7:0] er;
    eph = (m_pos < m_n);
    ep  = eph ? m_a : m_b;
    er  = m_cfg & 8'hF7;
    n_chk++;
    if (pwr_lvl !== ep || a_phase !== eph || reg_rdata !== er) begin
      n_bad++;
      $display("FAIL %s pos=%0d: pwr=%b ph=%b rd=%h expected pwr=%b ph=%b rd=%h",
               req, m_pos, pwr_lvl, a_phase, reg_rdata, ep, eph, er);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] wd, input logic st,
                      input logic tk, string req);
    reg_wr_en = wr; reg_wdata = wd; ivl_start = st; tick_en = tk;
    @(posedge clk);
    if (st || (tk && m_pos == m_len - 1)) begin
      m_pos = 0;
      m_len = wave_long ? 32 : 16;
      m_a = m_cfg[7:6]; m_b = m_cfg[5:4]; m_n = int'(m_cfg[2:0]);
    end else if (tk) m_pos++;
    if (wr) m_cfg = wd;
    @(negedge clk);
    reg_wr_en = 1'b0; ivl_start = 1'b0; tick_en = 1'b0;
    check(req);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    foreach (VEC[v]) begin
      wave_long = VEC[v][8];
      step(1'b1, VEC[v][7:0], 1'b0, 1'b0, "R2");
      step(1'b0, 8'h00, 1'b1, 1'b0, "R8");
      for (int k = 0; k < 2 * m_len; k++) begin
        if (k % 5 == 2) step(1'b0, 8'h00, 1'b0, 1'b0, "R7");
        step(1'b0, 8'h00, 1'b0, 1'b1, VEC[v][8] ? "R5" : "R4");
      end
    end

    // R6 / R3: N=0, only B level, phase low
    wave_long = 1'b0;
    step(1'b1, 8'h78, 1'b0, 1'b0, "R2");
    step(1'b0, 8'h00, 1'b1, 1'b0, "R6");
    for (int k = 0; k < 16; k++) step(1'b0, 8'h00, 1'b0, 1'b1, "R6");

    // R9: mid-interval write and waveform change wait for the boundary
    step(1'b1, 8'hA5, 1'b0, 1'b0, "R2");
    step(1'b0, 8'h00, 1'b1, 1'b0, "R10");
    for (int k = 0; k < 6; k++) step(1'b0, 8'h00, 1'b0, 1'b1, "R10");
    step(1'b1, 8'h1E, 1'b0, 1'b0, "R9");
    wave_long = 1'b1;
    for (int k = 0; k < 30; k++) step(1'b0, 8'h00, 1'b0, 1'b1, "R9");

    // R8: strobe wins over a tick mid-interval
    for (int k = 0; k < 3; k++) step(1'b0, 8'h00, 1'b0, 1'b1, "R11");
    step(1'b0, 8'h00, 1'b1, 1'b1, "R8");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R11");

    // R1: reset in the middle of activity
    rst_n = 1'b0;
    m_cfg = '0; m_pos = 0; m_len = 16; m_n = 0; m_a = '0; m_b = '0;
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    step(1'b0, 8'h00, 1'b0, 1'b1, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule